// File: doc/BRIEF.md
# Host-Paced I2C Receive Engine with Break Points

This block is the receive side of an I2C slave that does not step through a fixed protocol on its own. A host writes a request word. The word names the bus moments at which the engine should stop and raise an interrupt: a START, a STOP, a completed byte, or the acknowledge slot. The same word also sets the level the engine places in the acknowledge slot. After every taken break except the STOP break, the engine stretches the clock. It does this by pulling SCL low the next time SCL is low, and it keeps pulling until the host writes a new request. The bus therefore waits for software.

The engine reports on a status word. It shows which breaks are pending, the last byte received (MSB first), and a lost flag. The lost flag is set when the engine offers a released (high) acknowledge and then samples the line low. With the acknowledge level set to 1 and every break serviced at once, the engine never drives SDA. It acts as a passive snooper, and the lost flag reports the acknowledge that another device sent. SCL and SDA each pass through a two-flop synchronizer before any decoding. The outputs are pull-low enables only.

Top module: `swi_i2c_slave`

## Requirements
- R1: After reset, rd_data is 0, irq_o is 0, and scl_pull_o and sda_pull_o are both 0.
- R2: SDA falling while SCL is high is a START. When request bit 0 is set, it sets pending bit rd_data[8].
- R3: SDA rising while SCL is high is a STOP. When request bit 1 is set, it sets pending bit rd_data[9]. A request whose only break enable is bit 1 never causes scl_pull_o.
- R4: After a START, data bits are shifted MSB first on rising SCL. After the eighth rising edge, rd_data[7:0] holds the byte. When request bit 2 is set, that same rise sets pending bit rd_data[10].
- R5: The rising SCL edge inside the acknowledge slot sets pending bit rd_data[11] when request bit 3 is set.
- R6: A taken START, byte or acknowledge break sets the hold flag rd_data[13]. While the hold flag is set, scl_pull_o is asserted from the first time SCL is seen low, and it stays asserted.
- R7: A request write clears the pending bits, the lost flag, the hold flag, scl_pull_o and irq_o. Only an event that lands in the same cycle as the write survives it.
- R8: irq_o is 1 exactly when any pending bit rd_data[11:8] is 1.
- R9: A pending bit stays set until the next request write. A STOP break that has not been serviced and a following START break are both recorded.
- R10: Request bit 4 is the acknowledge level. With 0, sda_pull_o is asserted from the SCL fall after the eighth bit until the SCL fall that ends the acknowledge slot. With 1, sda_pull_o never rises.
- R11: Lost flag rd_data[12] is set when the acknowledge level is 1 and SDA is sampled low on the acknowledge-slot SCL rise. It stays 0 when SDA is high there or when the level is 0.
- R12: An event whose enable bit is 0 sets no pending bit and no hold flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sampled level of the SCL line |
| sda_i | input | 1 | Sampled level of the SDA line |
| scl_pull_o | output | 1 | Pull SCL low when 1 (clock stretch) |
| sda_pull_o | output | 1 | Pull SDA low when 1 (acknowledge) |
| wr_en | input | 1 | Request write strobe |
| wr_data | input | 5 | Request: [3:0] break enables (start, stop, byte, ack), [4] acknowledge level |
| rd_data | output | 16 | Status: [7:0] byte, [11:8] pending, [12] lost, [13] hold, [15:14] zero |
| irq_o | output | 1 | Interrupt, high while any break is pending |

## Verification
A bus change reaches the status three clock edges after the pin moves: two synchronizer stages, then the registered update. The bench therefore holds every bus phase for eight clocks and samples on falling clock edges at the end of the phase. The clearing effect of a write is checked on the first falling edge after the write. That moment comes before the freed SCL rise has passed the synchronizer, so any event caused by that rise cannot hide the clear. The bench sweeps all sixteen break-enable combinations against both acknowledge levels and both acknowledge answers from a modelled second device. For each combination it computes the expected pending set, hold, lost flag and byte.

// File: rtl/swi_pkg.sv
package swi_pkg;
  localparam int BYTE_W  = 8;
  localparam int NUM_BRK = 4;
  localparam int CNT_W   = $clog2(BYTE_W);
  localparam int REQ_W   = NUM_BRK + 1;
  localparam int STAT_W  = BYTE_W + NUM_BRK + 4;

  localparam int BRK_START = 0;
  localparam int BRK_STOP  = 1;
  localparam int BRK_BYTE  = 2;
  localparam int BRK_ACK   = 3;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_DATA,
    RX_ACK_PEND,
    RX_ACK,
    RX_ACK_DONE
  } rx_state_e;

  typedef struct packed {
    logic start;
    logic stop;
    logic rise;
    logic fall;
  } bus_ev_t;

  typedef struct packed {
    logic               ack_val;
    logic [NUM_BRK-1:0] en;
  } req_t;
endpackage

// File: rtl/swi_sync.sv
module swi_sync #(
  parameter int              WIDTH   = 2,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;
  logic [STAGES-1:0][WIDTH-1:0] stg_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb stg_d = d;
    end else begin : g_chain
      always_comb stg_d = {stg_q[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= {STAGES{RST_VAL}};
    else        stg_q <= stg_d;
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/swi_bus_mon.sv
module swi_bus_mon
  import swi_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    scl_s,
  input  logic    sda_s,
  output bus_ev_t ev
);
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  always_comb begin
    ev.rise  = scl_s & ~scl_d;
    ev.fall  = ~scl_s & scl_d;
    ev.start = scl_s & scl_d & sda_d & ~sda_s;
    ev.stop  = scl_s & scl_d & ~sda_d & sda_s;
  end
endmodule

// File: rtl/swi_rx_engine.sv
module swi_rx_engine
  import swi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  bus_ev_t           ev,
  input  logic              sda_s,
  input  logic              ack_next,
  output logic              byte_ev,
  output logic              ack_ev,
  output logic              ack_zero,
  output logic [BYTE_W-1:0] last_byte,
  output logic              sda_pull
);
  rx_state_e         state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] shreg_q, shreg_d;
  logic [BYTE_W-1:0] byte_q, byte_d;
  logic              drive_q, drive_d;
  logic [BYTE_W-1:0] shifted;

  assign shifted = {shreg_q[BYTE_W-2:0], sda_s};

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    shreg_d  = shreg_q;
    byte_d   = byte_q;
    byte_ev  = 1'b0;
    ack_ev   = 1'b0;
    ack_zero = 1'b0;
    if (ev.stop) begin
      state_d = RX_IDLE;
    end else if (ev.start) begin
      state_d = RX_DATA;
      cnt_d   = '0;
    end else begin
      case (state_q)
        RX_DATA: begin
          if (ev.rise) begin
            shreg_d = shifted;
            cnt_d   = cnt_q + 1'b1;
            if (cnt_q == CNT_W'(BYTE_W - 1)) begin
              byte_d  = shifted;
              byte_ev = 1'b1;
              state_d = RX_ACK_PEND;
            end
          end
        end
        RX_ACK_PEND: begin
          if (ev.fall) state_d = RX_ACK;
        end
        RX_ACK: begin
          if (ev.rise) begin
            ack_ev   = 1'b1;
            ack_zero = ~sda_s;
            state_d  = RX_ACK_DONE;
          end
        end
        RX_ACK_DONE: begin
          if (ev.fall) begin
            state_d = RX_DATA;
            cnt_d   = '0;
          end
        end
        default: state_d = RX_IDLE;
      endcase
    end
  end

  always_comb begin
    case (state_d)
      RX_ACK:      drive_d = ~ack_next;
      RX_ACK_DONE: drive_d = drive_q;
      default:     drive_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      shreg_q <= '0;
      byte_q  <= '0;
      drive_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      shreg_q <= shreg_d;
      byte_q  <= byte_d;
      drive_q <= drive_d;
    end
  end

  assign last_byte = byte_q;
  assign sda_pull  = drive_q;
endmodule

// File: rtl/swi_brk_ctrl.sv
module swi_brk_ctrl
  import swi_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [REQ_W-1:0]   wr_data,
  input  logic               ev_start,
  input  logic               ev_stop,
  input  logic               byte_ev,
  input  logic               ack_ev,
  input  logic               ack_zero,
  input  logic               scl_s,
  output logic               ack_next,
  output logic [NUM_BRK-1:0] pend,
  output logic               lost,
  output logic               hold,
  output logic               scl_pull,
  output logic               irq
);
  localparam logic [NUM_BRK-1:0] HOLD_MASK = ~(NUM_BRK'(1) << BRK_STOP);

  req_t               req_q, req_d;
  logic [NUM_BRK-1:0] pend_q, pend_d;
  logic               lost_q, lost_d;
  logic               hold_q, hold_d;
  logic               pull_q, pull_d;
  logic [NUM_BRK-1:0] raw_ev, taken;

  always_comb begin
    raw_ev            = '0;
    raw_ev[BRK_START] = ev_start;
    raw_ev[BRK_STOP]  = ev_stop;
    raw_ev[BRK_BYTE]  = byte_ev;
    raw_ev[BRK_ACK]   = ack_ev;
  end

  always_comb begin
    req_d  = wr_en ? req_t'(wr_data) : req_q;
    taken  = raw_ev & req_d.en;
    pend_d = (wr_en ? '0 : pend_q) | taken;
    hold_d = (wr_en ? 1'b0 : hold_q) | (|(taken & HOLD_MASK));
    lost_d = (wr_en ? 1'b0 : lost_q) | (ack_zero & req_d.ack_val);
    pull_d = hold_d & (pull_q | ~scl_s);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= '{ack_val: 1'b1, en: '0};
      pend_q <= '0;
      lost_q <= 1'b0;
      hold_q <= 1'b0;
      pull_q <= 1'b0;
    end else begin
      req_q  <= req_d;
      pend_q <= pend_d;
      lost_q <= lost_d;
      hold_q <= hold_d;
      pull_q <= pull_d;
    end
  end

  assign ack_next = req_d.ack_val;
  assign pend     = pend_q;
  assign lost     = lost_q;
  assign hold     = hold_q;
  assign scl_pull = pull_q;
  assign irq      = |pend_q;
endmodule

// File: rtl/swi_i2c_slave.sv
module swi_i2c_slave
  import swi_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_pull_o,
  output logic              sda_pull_o,
  input  logic              wr_en,
  input  logic [REQ_W-1:0]  wr_data,
  output logic [STAT_W-1:0] rd_data,
  output logic              irq_o
);
  logic               scl_s, sda_s;
  bus_ev_t            ev;
  logic               byte_ev, ack_ev, ack_zero, ack_next;
  logic [BYTE_W-1:0]  last_byte;
  logic [NUM_BRK-1:0] pend;
  logic               lost, hold;

  swi_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({scl_i, sda_i}),
    .q     ({scl_s, sda_s})
  );

  swi_bus_mon u_mon (
    .clk   (clk),
    .rst_n (rst_n),
    .scl_s (scl_s),
    .sda_s (sda_s),
    .ev    (ev)
  );

  swi_rx_engine u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev        (ev),
    .sda_s     (sda_s),
    .ack_next  (ack_next),
    .byte_ev   (byte_ev),
    .ack_ev    (ack_ev),
    .ack_zero  (ack_zero),
    .last_byte (last_byte),
    .sda_pull  (sda_pull_o)
  );

  swi_brk_ctrl u_brk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .ev_start (ev.start),
    .ev_stop  (ev.stop),
    .byte_ev  (byte_ev),
    .ack_ev   (ack_ev),
    .ack_zero (ack_zero),
    .scl_s    (scl_s),
    .ack_next (ack_next),
    .pend     (pend),
    .lost     (lost),
    .hold     (hold),
    .scl_pull (scl_pull_o),
    .irq      (irq_o)
  );

  assign rd_data = {2'b00, hold, lost, pend, last_byte};
endmodule

// File: rtl/swi_i2c_slave_chk.sv
module swi_i2c_slave_chk
  import swi_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               scl_pull_o,
  input logic               sda_pull_o,
  input logic               wr_en,
  input logic [REQ_W-1:0]   wr_data,
  input logic [NUM_BRK-1:0] pend,
  input logic               lost,
  input logic               hold
);
  logic [NUM_BRK-1:0] en_q;
  logic               ack_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      ack_q <= 1'b1;
    end else if (wr_en) begin
      en_q  <= wr_data[NUM_BRK-1:0];
      ack_q <= wr_data[NUM_BRK];
    end
  end

  AST_STOP_NO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((en_q & 4'b1101) == 4'b0000) |-> !scl_pull_o); // R3
  AST_PULL_NEEDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    scl_pull_o |-> hold); // R6
  AST_HOLD_ENDS_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold) |-> $past(wr_en)); // R7
  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(pend) & ~pend) != 4'b0000) |-> $past(wr_en)); // R9
  AST_PASSIVE_SDA: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull_o) |-> !ack_q); // R10
  AST_LOST_ONLY_PASSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lost) |-> ack_q); // R11
  AST_NOEN_NOPEND: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[NUM_BRK-1:0] == 4'b0000) |=> (pend == 4'b0000)); // R12
endmodule

bind swi_i2c_slave swi_i2c_slave_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .scl_pull_o (scl_pull_o),
  .sda_pull_o (sda_pull_o),
  .wr_en      (wr_en),
  .wr_data    (wr_data),
  .pend       (rd_data[11:8]),
  .lost       (rd_data[12]),
  .hold       (rd_data[13])
);

// File: tb/sim_swi_i2c_slave.sv
module sim_swi_i2c_slave;
  localparam int T = 8;
  localparam int GAP = 80;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        m_scl, m_sda, o_ack;
  logic        scl_bus, sda_bus;
  logic        scl_pull_o, sda_pull_o, wr_en, irq_o;
  logic [4:0]  wr_data;
  logic [15:0] rd_data;

  int          n_vec = 0;
  int          n_bad = 0;
  logic [3:0]  exp_pend;
  logic        exp_hold, exp_lost;
  logic [3:0]  cur_m;
  logic        cur_a;

  always #10 clk = ~clk;

  assign scl_bus = m_scl & ~scl_pull_o;
  assign sda_bus = m_sda & o_ack & ~sda_pull_o;

  swi_i2c_slave u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_bus),
    .sda_i      (sda_bus),
    .scl_pull_o (scl_pull_o),
    .sda_pull_o (sda_pull_o),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .rd_data    (rd_data),
    .irq_o      (irq_o)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s m=%0h a=%0d got=%0h exp=%0h", req, cur_m, cur_a, got, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic host_write(input logic [3:0] m, input logic a);
    wr_en   = 1'b1;
    wr_data = {a, m};
    wclk(1);
    wr_en    = 1'b0;
    exp_pend = 4'h0;
    exp_hold = 1'b0;
    exp_lost = 1'b0;
  endtask

  task automatic take(input logic [3:0] ev);
    if ((cur_m & ev) != 4'h0) begin
      exp_pend = exp_pend | ev;
      if (ev != 4'h2) exp_hold = 1'b1;
    end
  endtask

  task automatic chk_pend(input string req);
    chk(req, 32'(rd_data[11:8]), 32'(exp_pend));
    chk("R8", 32'(irq_o), 32'(exp_pend != 4'h0));
    chk(req, 32'(rd_data[13]), 32'(exp_hold));
  endtask

  task automatic scl_low();
    m_scl = 1'b0;
    wclk(T);
    if (exp_hold) chk("R6 pull", 32'(scl_pull_o), 32'd1);
  endtask

  task automatic scl_high();
    m_scl = 1'b1;
    wclk(T);
    chk("R6 stretch", 32'(scl_pull_o), 32'(exp_hold));
    if (exp_hold) begin
      host_write(cur_m, cur_a);
      chk("R7 clear", 32'({scl_pull_o, irq_o, rd_data[13:8]}), 32'd0);
      wclk(T);
    end
  endtask

  task automatic transaction(input logic [3:0] m, input logic a, input logic b, input logic [7:0] d);
    cur_m = m;
    cur_a = a;
    host_write(m, a);
    m_sda = 1'b0;
    wclk(T);
    take(4'h1);
    chk_pend((m == 4'h0) ? "R12" : "R2");
    for (int i = 7; i >= 0; i--) begin
      scl_low();
      m_sda = d[i];
      wclk(2);
      scl_high();
    end
    take(4'h4);
    chk_pend("R4");
    chk("R4 byte", 32'(rd_data[7:0]), 32'(d));
    scl_low();
    m_sda = 1'b1;
    o_ack = b;
    wclk(T);
    chk("R10 drive", 32'(sda_pull_o), 32'(!a));
    scl_high();
    take(4'h8);
    exp_lost = a & !b;
    chk("R11", 32'(rd_data[12]), 32'(exp_lost));
    chk_pend("R5");
    scl_low();
    o_ack = 1'b1;
    m_sda = 1'b0;
    wclk(T);
    chk("R10 release", 32'(sda_pull_o), 32'd0);
    scl_high();
    m_sda = 1'b1;
    wclk(T);
    take(4'h2);
    chk_pend("R3");
    chk("R3 no hold", 32'(scl_pull_o), 32'd0);
    chk("R11 keep", 32'(rd_data[12]), 32'(exp_lost));
    wclk(GAP);
    m_sda = 1'b0;
    wclk(T);
    take(4'h1);
    chk_pend("R9");
    m_sda = 1'b1;
    wclk(T);
    take(4'h2);
    chk_pend("R9");
    wclk(GAP);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    rst_n    = 1'b0;
    m_scl    = 1'b1;
    m_sda    = 1'b1;
    o_ack    = 1'b1;
    wr_en    = 1'b0;
    wr_data  = 5'h0;
    cur_m    = 4'h0;
    cur_a    = 1'b1;
    exp_pend = 4'h0;
    exp_hold = 1'b0;
    exp_lost = 1'b0;
    wclk(3);
    rst_n = 1'b1;
    wclk(3);
    chk("R1 status", 32'(rd_data), 32'd0);
    chk("R1 irq", 32'(irq_o), 32'd0);
    chk("R1 pulls", 32'({scl_pull_o, sda_pull_o}), 32'd0);
    for (int a = 0; a < 2; a++) begin
      for (int b = 0; b < 2; b++) begin
        for (int m = 0; m < 16; m++) begin
          transaction(4'(m), 1'(a), 1'(b), 8'(m * 29 + a * 83 + b * 151 + 7));
        end
      end
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule